// File: doc/BRIEF.md
# Four-channel load-strobed clock divider

This unit takes one fast source clock and produces four divided clock-enable streams, one per consumer domain: system bus, graphics, video engine and display. Each output is a single-cycle pulse that repeats every N source cycles, where N is that channel's active ratio. At a 2 GHz source the output frequency is 2 GHz divided by N.

Software sets the ratios through a small 32-bit register port with two words. The first word holds one staged ratio field per channel and, beside each field, a load bit. Writing a field only stages a value. The new value is committed when that channel's load bit goes from 0 to 1. The second word holds a run bit and a sticky error flag. The run bit is an active-low reset for the dividers: while it is 0, every divider is held still with its output low. The bus channel reads its field as a code and maps it to a ratio through a fixed table. The other three channels use the field value as the ratio. A committed ratio does not take effect at once. It waits for the end of the current division period, so no output period is ever cut short.

The register port and the enable outputs are plain control pins. They have no valid/ready handshake and no back-pressure. A write completes on the clock edge where `reg_we` is high, and a read returns data combinationally from `reg_addr`.

Top module: `clkdiv_unit`

## Requirements
- R1: After reset, word 0 reads 0x01020402. This is code 1 in the bus field and ratio 4 in the graphics, video and display fields, with all load bits 0. Word 1 reads 0, and `div_ce` is all zero.
- R2: Word 0 is at byte address 0 and word 1 at byte address 4. In word 0 the fields are bus in bits 6:1 (load bit 7), graphics in bits 13:8 (load 14), video in bits 20:15 (load 21) and display in bits 27:22 (load 28). Reads return the staged values as written. In word 1, bit 10 is the run bit, which software can write, and bit 0 is the error flag, which is read-only. Writes to any other address change nothing, and reads from any other address return 0.
- R3: While the run bit is 0, every `div_ce` bit stays low, and a rising load bit commits nothing and raises no error.
- R4: While the run bit is 1, each channel pulses its `div_ce` bit for one cycle every N cycles, where N is its active ratio. A ratio of 1 keeps the bit high on every cycle.
- R5: Writing a field without a 0-to-1 change of its load bit leaves that channel's rate unchanged. This includes rewriting the field while the load bit is held at 1.
- R6: A ratio committed while the run bit is 1 takes effect at the channel's next pulse. Every output period is then either the full old ratio or the full new one.
- R7: The bus field codes 1 to 10 give ratios 2, 1, 3, 4, 6, 5, 7, 8, 10, 9, in that order.
- R8: For graphics, video and display the field value is the ratio. Values 1 to 63 are legal.
- R9: Committing bus code 0, a bus code of 11 or above, or a direct field of 0 leaves the active ratio unchanged and sets the error flag (word 1 bit 0). The flag stays set until reset.
- R10: A commit on one channel does not change the rate of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte address of the register word |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| div_ce | output | 4 | Enable pulses: bit 0 bus, 1 graphics, 2 video, 3 display |

## Verification
The bench goes after the following corner cases.

- **Load bit held at 1 while the field is rewritten (R5).** A design that commits on the level of the load bit rather than its edge would switch to the later value.
- **Load edge while the run bit is 0 (R3).** A design that does not gate commits with the run bit would come out of hold at the new rate.
- **Reload in the middle of a long period (R6).** A design that reloads at once would produce a shortened period that is neither the old ratio nor the new one.
- **The full bus code table and the invalid codes 0, 11 and direct 0 (R7, R9).** Each entry is checked, so a swapped table entry shows as a wrong period. Accepting a bad code would stall a channel at ratio 0 or leave the error flag clear.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned OFS_CTRL0 = 0;
  localparam int unsigned OFS_CTRL1 = 4;
  localparam int unsigned RUN_BIT = 10;
  localparam int unsigned ERR_BIT = 0;
  localparam int unsigned BUS_RST_CODE = 1;
  localparam int unsigned BUS_RST_RATIO = 2;
  localparam int unsigned DIRECT_RST_RATIO = 4;

  // lowest bit of a channel's field; each field is followed by its load bit
  function automatic int unsigned fld_lo(int unsigned ch, int unsigned fw);
    return 1 + ch * (fw + 1);
  endfunction

  function automatic int unsigned ld_pos(int unsigned ch, int unsigned fw);
    return fld_lo(ch, fw) + fw;
  endfunction

  function automatic logic [DATA_W-1:0] word0_mask(int unsigned n, int unsigned fw);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int unsigned c = 0; c < n; c++)
      for (int unsigned b = 0; b <= fw; b++)
        m[fld_lo(c, fw) + b] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] word0_reset(int unsigned n, int unsigned fw);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int unsigned c = 0; c < n; c++)
      w = w | (DATA_W'((c == 0) ? BUS_RST_CODE : DIRECT_RST_RATIO) << fld_lo(c, fw));
    return w;
  endfunction
endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode #(
  parameter int unsigned FIELD_W   = 6,
  parameter bit          USE_TABLE = 1'b0
) (
  input  logic [FIELD_W-1:0] code,
  output logic [FIELD_W-1:0] ratio,
  output logic               ok
);
  if (USE_TABLE) begin : g_table
    // permuted code-to-ratio map of the bus channel (R7)
    always_comb begin
      ok = 1'b1;
      case (code)
        FIELD_W'(1):  ratio = FIELD_W'(2);
        FIELD_W'(2):  ratio = FIELD_W'(1);
        FIELD_W'(3):  ratio = FIELD_W'(3);
        FIELD_W'(4):  ratio = FIELD_W'(4);
        FIELD_W'(5):  ratio = FIELD_W'(6);
        FIELD_W'(6):  ratio = FIELD_W'(5);
        FIELD_W'(7):  ratio = FIELD_W'(7);
        FIELD_W'(8):  ratio = FIELD_W'(8);
        FIELD_W'(9):  ratio = FIELD_W'(10);
        FIELD_W'(10): ratio = FIELD_W'(9);
        default: begin
          ratio = '0;
          ok    = 1'b0;
        end
      endcase
    end
  end else begin : g_direct
    // field is the ratio; zero is rejected (R8, R9)
    assign ratio = code;
    assign ok    = (code != '0);
  end
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan #(
  parameter int unsigned FIELD_W   = 6,
  parameter int unsigned RST_RATIO = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               commit,
  input  logic [FIELD_W-1:0] new_ratio,
  input  logic               new_ok,
  output logic               ce,
  output logic [FIELD_W-1:0] ratio,
  output logic               bad
);
  logic [FIELD_W-1:0] cnt_q;
  logic [FIELD_W-1:0] ratio_q;
  logic [FIELD_W-1:0] pend_q;
  logic               pend_v_q;
  logic               tc;

  assign tc = run && (cnt_q == ratio_q - FIELD_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      ratio_q  <= FIELD_W'(RST_RATIO);
      pend_q   <= '0;
      pend_v_q <= 1'b0;
    end else begin
      if (!run || tc) cnt_q <= '0;
      else            cnt_q <= cnt_q + FIELD_W'(1);
      // a staged ratio is adopted only at the end of a whole period
      if (tc && pend_v_q) ratio_q <= pend_q;
      if (commit && new_ok) begin
        pend_q   <= new_ratio;
        pend_v_q <= 1'b1;
      end else if (tc) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assign ce    = tc;
  assign ratio = ratio_q;
  assign bad   = commit && !new_ok;
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic                            bad_commit,
  output logic [DATA_W-1:0]               rdata,
  output logic                            run,
  output logic                            err,
  output logic [N_CH-1:0][FIELD_W-1:0]    field,
  output logic [N_CH-1:0]                 ld_rise
);
  localparam logic [DATA_W-1:0] W0_MASK = word0_mask(N_CH, FIELD_W);
  localparam logic [DATA_W-1:0] W0_RST  = word0_reset(N_CH, FIELD_W);
  localparam logic [ADDR_W-1:0] A_CTRL0 = ADDR_W'(OFS_CTRL0);
  localparam logic [ADDR_W-1:0] A_CTRL1 = ADDR_W'(OFS_CTRL1);

  logic [DATA_W-1:0] ctrl0_q;
  logic [N_CH-1:0]   ld_now;
  logic [N_CH-1:0]   ld_prev_q;
  logic              sel0;
  logic              sel1;

  assign sel0 = (addr == A_CTRL0);
  assign sel1 = (addr == A_CTRL1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl0_q   <= W0_RST;
      run       <= 1'b0;
      err       <= 1'b0;
      ld_prev_q <= '0;
    end else begin
      if (we && sel0) ctrl0_q <= wdata & W0_MASK;
      if (we && sel1) run <= wdata[RUN_BIT];
      if (bad_commit) err <= 1'b1;
      ld_prev_q <= ld_now;
    end
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam int unsigned LO = fld_lo(ch, FIELD_W);
    localparam int unsigned LD = ld_pos(ch, FIELD_W);
    assign field[ch]   = ctrl0_q[LO +: FIELD_W];
    assign ld_now[ch]  = ctrl0_q[LD];
    assign ld_rise[ch] = ld_now[ch] & ~ld_prev_q[ch] & run;
  end

  always_comb begin
    rdata = '0;
    if (sel0) begin
      rdata = ctrl0_q;
    end else if (sel1) begin
      rdata[RUN_BIT] = run;
      rdata[ERR_BIT] = err;
    end
  end
endmodule

// File: rtl/clkdiv_unit.sv
module clkdiv_unit
  import clkdiv_pkg::*;
#(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned FIELD_W = 6,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [N_CH-1:0]   div_ce
);
  logic                         run_q;
  logic                         err_q;
  logic [N_CH-1:0][FIELD_W-1:0] field;
  logic [N_CH-1:0]              ld_rise;
  logic [N_CH-1:0][FIELD_W-1:0] dec_ratio;
  logic [N_CH-1:0]              dec_ok;
  logic [N_CH-1:0][FIELD_W-1:0] act_ratio;
  logic [N_CH-1:0]              bad_vec;
  logic                         bad_any;

  assign bad_any = |bad_vec;

  clkdiv_regs #(.N_CH(N_CH), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .bad_commit(bad_any), .rdata(reg_rdata), .run(run_q), .err(err_q),
    .field(field), .ld_rise(ld_rise)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam bit          IS_BUS = (ch == 0);
    localparam int unsigned RST_R  = IS_BUS ? BUS_RST_RATIO : DIRECT_RST_RATIO;

    clkdiv_decode #(.FIELD_W(FIELD_W), .USE_TABLE(IS_BUS)) u_dec (
      .code(field[ch]), .ratio(dec_ratio[ch]), .ok(dec_ok[ch])
    );

    clkdiv_chan #(.FIELD_W(FIELD_W), .RST_RATIO(RST_R)) u_chan (
      .clk(clk), .rst_n(rst_n), .run(run_q), .commit(ld_rise[ch]),
      .new_ratio(dec_ratio[ch]), .new_ok(dec_ok[ch]),
      .ce(div_ce[ch]), .ratio(act_ratio[ch]), .bad(bad_vec[ch])
    );
  end
endmodule

// File: rtl/clkdiv_unit_chk.sv
module clkdiv_unit_chk #(
  parameter int unsigned N_CH    = 4,
  parameter int unsigned FIELD_W = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         run,
  input logic                         err,
  input logic [N_CH-1:0]              div_ce,
  input logic [N_CH-1:0][FIELD_W-1:0] act_ratio,
  input logic                         bad_commit
);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> div_ce == '0);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(act_ratio));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(bad_commit));

  assert_bus_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_ratio[0] <= FIELD_W'(10));

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    assert_switch_at_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act_ratio[ch] != $past(act_ratio[ch])) |-> $past(div_ce[ch]));

    assert_ratio_nonzero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      act_ratio[ch] != '0);
  end
endmodule

bind clkdiv_unit clkdiv_unit_chk #(.N_CH(N_CH), .FIELD_W(FIELD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_q), .err(err_q), .div_ce(div_ce),
  .act_ratio(act_ratio), .bad_commit(bad_any)
);

// File: tb/tb_clkdiv_unit.sv
module tb_clkdiv_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  div_ce;

  always #10 clk = ~clk;

  clkdiv_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .div_ce(div_ce)
  );

  typedef struct {
    int    ch;
    int    exp;
    string tag;
  } item_t;

  item_t       q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] shadow;
  int          bus_tab[11] = '{0, 2, 1, 3, 4, 6, 5, 7, 8, 10, 9};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int lo(input int ch);
    return 1 + ch * 7;
  endfunction

  function automatic logic [31:0] put_field(input logic [31:0] w, input int ch, input int v);
    logic [31:0] r;
    r = w & ~(32'h3F << lo(ch));
    r = r & ~(32'h1 << (lo(ch) + 6));
    return r | ((32'(v) & 32'h3F) << lo(ch));
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // staged write, load high for longer than 250 ns, load low again
  task automatic reload(input int ch, input int v);
    shadow = put_field(shadow, ch, v);
    wr(3'd0, shadow);
    wr(3'd0, shadow | (32'h1 << (lo(ch) + 6)));
    repeat (15) @(negedge clk);
    wr(3'd0, shadow);
  endtask

  task automatic measure(input int ch, output int gap);
    int t;
    do @(negedge clk); while (!div_ce[ch]);
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!div_ce[ch]);
    gap = t;
  endtask

  // driver side of the scoreboard
  task automatic expect_period(input int ch, input int exp, input string tag);
    q.push_back('{ch: ch, exp: exp, tag: tag});
    while (q.size() != 0) @(negedge clk);
  endtask

  // monitor side: pops expected periods and compares them with the outputs
  initial begin
    item_t it;
    int    g;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q[0];
        measure(it.ch, g);
        measure(it.ch, g);
        check(g == it.exp, it.tag, g, it.exp);
        void'(q.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R4 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int          seen;
    int          t;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values and quiet outputs
    rd(3'd0, d); check(d == 32'h01020402, "R1 word0 reset", int'(d), 32'h01020402);
    rd(3'd4, d); check(d == 32'h0, "R1 word1 reset", int'(d), 0);
    seen = 0;
    repeat (20) begin @(negedge clk); if (div_ce != 0) seen++; end
    check(seen == 0, "R1 div_ce idle after reset", seen, 0);
    shadow = 32'h01020402;

    // R3: a commit while held is ignored
    seen = 0;
    fork
      reload(1, 7);
      repeat (40) begin @(negedge clk); if (div_ce != 0) seen++; end
    join
    check(seen == 0, "R3 div_ce low while held", seen, 0);
    wr(3'd4, 32'h400);
    expect_period(1, 4, "R3 graphics ratio kept across held commit");
    rd(3'd4, d); check(d == 32'h400, "R3 no error from held commit", int'(d), 32'h400);

    // R4: reset ratios once running
    expect_period(0, 2, "R4 bus period 2");
    expect_period(2, 4, "R4 video period 4");
    expect_period(3, 4, "R4 display period 4");

    // R2: readback and unmapped address
    rd(3'd0, d); check(d == shadow, "R2 staged word0 readback", int'(d), int'(shadow));
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd0, d); check(d == shadow, "R2 unmapped write ignored", int'(d), int'(shadow));
    rd(3'd1, d); check(d == 32'h0, "R2 unmapped read zero", int'(d), 0);

    // R5: field write without a load edge
    shadow = put_field(shadow, 1, 9);
    wr(3'd0, shadow);
    expect_period(1, 4, "R5 field write without load");
    wr(3'd0, shadow | (32'h1 << 14));
    wr(3'd0, put_field(shadow, 1, 12) | (32'h1 << 14));
    repeat (5) @(negedge clk);
    shadow = put_field(shadow, 1, 12);
    wr(3'd0, shadow);
    expect_period(1, 9, "R5 rewrite while load held high");

    // R6: reload mid-period gives only whole periods
    shadow = put_field(shadow, 1, 3);
    wr(3'd0, shadow);
    wr(3'd0, shadow | (32'h1 << 14));
    do @(negedge clk); while (!div_ce[1]);
    for (int k = 0; k < 4; k++) begin
      t = 0;
      do begin @(negedge clk); t++; end while (!div_ce[1]);
      if (k == 3) check(t == 3, "R6 new ratio in effect", t, 3);
      else        check(t == 9 || t == 3, "R6 whole period only", t, 3);
    end
    wr(3'd0, shadow);

    // R7: bus code table
    for (int c = 1; c <= 10; c++) begin
      reload(0, c);
      expect_period(0, bus_tab[c], $sformatf("R7 bus code %0d", c));
    end

    // R8: direct ratios including limits
    reload(1, 1);  expect_period(1, 1, "R8 graphics ratio 1");
    reload(2, 63); expect_period(2, 63, "R8 video ratio 63");
    reload(3, 17); expect_period(3, 17, "R8 display ratio 17");
    reload(1, 5);  expect_period(1, 5, "R8 graphics ratio 5");

    // R10: other channels unaffected
    expect_period(2, 63, "R10 video kept");
    expect_period(0, 9, "R10 bus kept");

    // R9: invalid commits
    rd(3'd4, d); check(d[0] == 1'b0, "R9 error clear before bad commit", int'(d[0]), 0);
    reload(0, 0);
    expect_period(0, 9, "R9 bus code 0 ignored");
    rd(3'd4, d); check(d[0] == 1'b1, "R9 error set", int'(d[0]), 1);
    reload(0, 11);
    expect_period(0, 9, "R9 bus code 11 ignored");
    reload(2, 0);
    expect_period(2, 63, "R9 video zero ignored");
    reload(0, 3);
    expect_period(0, 3, "R9 valid commit after error");
    rd(3'd4, d); check(d == 32'h401, "R9 error sticky", int'(d), 32'h401);

    finish_run();
  end
endmodule